// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block regulates the current in one full bridge by fixed off-time pulse-width modulation. While enabled it keeps the bridge in a conducting drive phase until an external sense comparator signals that the winding current has reached its trip level. The comparator asserts `trip` once three times the sense voltage reaches the reference level. On a valid trip the drive phase is cleared and a one-shot off-time starts. During the off-time the current decays in slow or fast mode, chosen by `slow_sel`. When the one-shot expires, the drive phase resumes by itself.

Switching the bridge produces recovery and capacitive transients that can falsely trip the comparator. For this reason, after every internally commanded switch (entry into the drive phase and entry into the off-time) the trip input is masked for a blanking window, and `blanking` is raised for that window. A trip that arrives while it is masked, or during the off-time, is dropped and not remembered. Both window lengths are parameters counted in clock cycles: `BLANK_CYC` (default 3) and `OFF_CYC` (default 30). These defaults correspond to 3 µs and 30 µs at a 1 MHz clock. All outputs come straight from registers. Later stages use them to drive the bridge gates.

Top module: `offtime_chopper`

## Requirements
- R1: While `rst` is high at a clock edge, all four outputs (`drive_on`, `blanking`, `off_slow`, `off_fast`) are 0 after that edge.
- R2: With `enable` high in idle, the edge that samples it sets `drive_on`=1 and `blanking`=1.
- R3: After each entry into the drive phase or the off-time, `blanking` stays 1 for exactly `BLANK_CYC` cycles. A `trip` sampled at an edge where `blanking` is 1 has no effect, and `drive_on` stays 1.
- R4: With `drive_on`=1 and `blanking`=0, a `trip` of 1 at an edge starts the off-time. After that edge `drive_on`=0, `blanking`=1 and one of `off_slow`/`off_fast` is 1.
- R5: The off-time lasts exactly `OFF_CYC` cycles while `enable` stays high. After it, `drive_on` and `blanking` return to 1 without any input.
- R6: A trip during the off-time is discarded. After the drive phase resumes, `drive_on` stays 1 past the blanking window unless a new trip arrives.
- R7: During the off-time, `off_slow`=1 if `slow_sel` was 1 at the previous edge, and `off_fast`=1 otherwise. Outside the off-time both are 0. At most one of `drive_on`, `off_slow` and `off_fast` is 1.
- R8: `enable` low at an edge returns the block to idle from any phase, including a running off-time. After that edge all outputs are 0, and it takes priority over a simultaneous trip.
- R9: With `trip` held high, each drive phase lasts exactly `BLANK_CYC`+1 cycles. The trip is taken at the first edge after the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Bridge enable; low forces idle |
| trip | input | 1 | Current-sense comparator trip, active high |
| slow_sel | input | 1 | Decay select during off-time: 1 slow, 0 fast |
| drive_on | output | 1 | Drive phase active (diagonal pair conducting) |
| blanking | output | 1 | Comparator masking window active |
| off_slow | output | 1 | Off-time with slow decay |
| off_fast | output | 1 | Off-time with fast decay |

## Verification
Two things can meet at the same edge: a comparator trip and the closing of the blanking window. A trip can also meet an enable drop. The bench holds `trip` high from the start of a drive phase. It then checks that the trip is refused at the edge where `blanking` is still 1 and taken at the very next edge, so the drive phase is `BLANK_CYC`+1 cycles long. In a separate step it pulls `enable` low in the same cycle as a valid trip and expects idle rather than the off-time.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2
  } phase_t;
endpackage

// File: rtl/chop_timer.sv
// One-shot down counter: load sets MAX, counts to zero, then idles.
module chop_timer #(
  parameter int MAX = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic load,
  output logic busy,
  output logic last
);
  localparam int W = $clog2(MAX + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= W'(MAX);
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign busy = (cnt != '0);
  assign last = (cnt == W'(1));
endmodule

// File: rtl/chop_fsm.sv
// Phase control: idle, drive, fixed off-time. Outputs are registered.
module chop_fsm
  import chop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic trip,
  input  logic slow_sel,
  input  logic blank_busy,
  input  logic off_last,
  output logic blank_load,
  output logic off_load,
  output logic timer_clr,
  output logic drive_on,
  output logic off_slow,
  output logic off_fast
);
  phase_t st, nxt;

  always_comb begin
    nxt        = st;
    blank_load = 1'b0;
    off_load   = 1'b0;
    timer_clr  = 1'b0;
    if (!enable) begin
      nxt       = PH_IDLE;
      timer_clr = 1'b1;
    end else begin
      case (st)
        PH_IDLE: begin
          nxt        = PH_ON;
          blank_load = 1'b1;
        end
        PH_ON: begin
          if (trip && !blank_busy) begin
            nxt        = PH_OFF;
            off_load   = 1'b1;
            blank_load = 1'b1;
          end
        end
        PH_OFF: begin
          if (off_last) begin
            nxt        = PH_ON;
            blank_load = 1'b1;
          end
        end
        default: nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PH_IDLE;
      drive_on <= 1'b0;
      off_slow <= 1'b0;
      off_fast <= 1'b0;
    end else begin
      st       <= nxt;
      drive_on <= (nxt == PH_ON);
      off_slow <= (nxt == PH_OFF) && slow_sel;
      off_fast <= (nxt == PH_OFF) && !slow_sel;
    end
  end
endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper #(
  parameter int BLANK_CYC = 3,
  parameter int OFF_CYC   = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic trip,
  input  logic slow_sel,
  output logic drive_on,
  output logic blanking,
  output logic off_slow,
  output logic off_fast
);
  logic blank_load, off_load, timer_clr;
  logic blank_busy, blank_last_unused;
  logic off_busy_unused, off_last;

  chop_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .trip       (trip),
    .slow_sel   (slow_sel),
    .blank_busy (blank_busy),
    .off_last   (off_last),
    .blank_load (blank_load),
    .off_load   (off_load),
    .timer_clr  (timer_clr),
    .drive_on   (drive_on),
    .off_slow   (off_slow),
    .off_fast   (off_fast)
  );

  chop_timer #(.MAX(BLANK_CYC)) u_blank (
    .clk   (clk),
    .rst   (rst),
    .clear (timer_clr),
    .load  (blank_load),
    .busy  (blank_busy),
    .last  (blank_last_unused)
  );

  chop_timer #(.MAX(OFF_CYC)) u_off (
    .clk   (clk),
    .rst   (rst),
    .clear (timer_clr),
    .load  (off_load),
    .busy  (off_busy_unused),
    .last  (off_last)
  );

  assign blanking = blank_busy;
endmodule

// File: rtl/offtime_chopper_chk.sv
module offtime_chopper_chk #(
  parameter int OFF_CYC = 30
) (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic trip,
  input logic drive_on,
  input logic blanking,
  input logic off_slow,
  input logic off_fast
);
  localparam int RW = $clog2(OFF_CYC + 2);

  logic          off_any;
  logic [RW-1:0] run;

  assign off_any = off_slow || off_fast;

  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (off_any) run <= run + RW'(1);
    else run <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !drive_on && !blanking && !off_slow && !off_fast); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !drive_on && !blanking && !off_slow && !off_fast); // R8

  AST_ENTRY_BLANKED: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_on) |-> blanking); // R2

  AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    enable && drive_on && blanking |=> drive_on); // R3

  AST_TRIP_CUTS: assert property (@(posedge clk) disable iff (rst)
    enable && drive_on && !blanking && trip |=> !drive_on && blanking && off_any); // R4

  AST_OFF_BOUND: assert property (@(posedge clk) disable iff (rst)
    off_any |-> (int'(run) < OFF_CYC)); // R5

  AST_OFF_LENGTH: assert property (@(posedge clk) disable iff (rst)
    drive_on && !off_any && (run != '0) |-> (int'(run) == OFF_CYC)); // R5

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({drive_on, off_slow, off_fast})); // R7
endmodule

bind offtime_chopper offtime_chopper_chk #(.OFF_CYC(OFF_CYC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .trip     (trip),
  .drive_on (drive_on),
  .blanking (blanking),
  .off_slow (off_slow),
  .off_fast (off_fast)
);

// File: tb/offtime_chopper_test.sv
module offtime_chopper_test;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK_CYC  = 3;
  localparam int OFF_CYC    = 30;

  logic clk = 1'b0;
  logic rst, enable, trip, slow_sel;
  logic drive_on, blanking, off_slow, off_fast;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  offtime_chopper #(.BLANK_CYC(BLANK_CYC), .OFF_CYC(OFF_CYC)) uut (
    .clk(clk), .rst(rst), .enable(enable), .trip(trip), .slow_sel(slow_sel),
    .drive_on(drive_on), .blanking(blanking), .off_slow(off_slow), .off_fast(off_fast)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  // vector order: {drive_on, blanking, off_slow, off_fast}
  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {drive_on, blanking, off_slow, off_fast};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs %b, expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; enable = 1'b1; trip = 1'b0; slow_sel = 1'b0;
    tick(); tick();
    chk("R1 reset", 4'b0000);
    enable = 1'b0;
    rst = 1'b0;
    tick();
    chk("R1 idle after reset", 4'b0000);
  endtask

  task automatic t_start();
    enable = 1'b1;
    tick(); chk("R2 enable entry", 4'b1100);
    tick(); chk("R3 blank cycle 2", 4'b1100);
    trip = 1'b1;
    tick(); chk("R3 trip in blanking ignored", 4'b1100);
    trip = 1'b0;
    tick(); chk("R3 window closes after BLANK_CYC", 4'b1000);
  endtask

  task automatic t_offtime();
    slow_sel = 1'b1; trip = 1'b1;
    tick(); chk("R4 trip starts off-time slow", 4'b0110);
    trip = 1'b0;
    tick(); tick(); chk("R3 off blanking last cycle", 4'b0110);
    tick(); chk("R7 slow decay unblanked", 4'b0010);
    slow_sel = 1'b0;
    tick(); chk("R7 fast decay follows select", 4'b0001);
    trip = 1'b1;
    tick(); chk("R6 trip in off-time ignored", 4'b0001);
    trip = 1'b0;
    for (int i = 6; i < OFF_CYC; i++) tick();
    chk("R5 last off cycle", 4'b0001);
    tick(); chk("R5 resume after OFF_CYC", 4'b1100);
    tick(); tick(); tick();
    chk("R6 no queued trip after resume", 4'b1000);
  endtask

  task automatic t_abort();
    trip = 1'b1;
    tick(); chk("R4 second trip", 4'b0101);
    trip = 1'b0;
    tick(); tick();
    enable = 1'b0;
    tick(); chk("R8 abort off-time", 4'b0000);
    enable = 1'b1;
    tick(); chk("R2 re-entry after abort", 4'b1100);
    tick(); tick(); tick();
    chk("R3 re-entry window closed", 4'b1000);
    enable = 1'b0; trip = 1'b1;
    tick(); chk("R8 disable beats trip", 4'b0000);
    trip = 1'b0;
    tick(); chk("R8 stays idle", 4'b0000);
  endtask

  task automatic t_held_trip();
    int n;
    enable = 1'b1; trip = 1'b1;
    tick();
    n = 0;
    while (drive_on && n < 100) begin n++; tick(); end
    chk_int("R9 held trip on-length", n, BLANK_CYC + 1);
    n = 0;
    while (!drive_on && n < 100) begin n++; tick(); end
    chk_int("R5 off-length with held trip", n, OFF_CYC);
    chk("R5 resume blanked", 4'b1100);
    n = 0;
    while (drive_on && n < 100) begin n++; tick(); end
    chk_int("R9 second on-length", n, BLANK_CYC + 1);
    trip = 1'b0; enable = 1'b0;
    tick();
  endtask

  initial begin
    t_reset();
    t_start();
    t_offtime();
    t_abort();
    t_held_trip();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule